// File: doc/BRIEF.md
# Four-Channel Single-Byte DMA Transfer Sequencer

This block is the transfer engine behind a four-channel DMA controller. It watches the per-channel request lines and serves one byte for the highest-priority request that is eligible. To serve it, the block takes the bus, acknowledges the winning channel, puts that channel's current memory address on the address bus and pulses the command strobes that the channel's transfer type calls for. It then hands the bus back. Every grant moves exactly one byte, so a device that wants more data must keep requesting, and each request is arbitrated again from scratch.

The register interface writes a start address and a transfer count into each channel. It also supplies the mode of each channel: transfer type, address direction and auto-reload. Masks are set and cleared with one-cycle pulses. The sequencer keeps the live address and count itself and steps them after every byte. When a channel's count runs out, the sequencer pulses terminal count. The channel then either masks itself or reloads from its start values. The block has no streaming data path. The request and acknowledge pins are plain levels: a device holds its request until it sees its acknowledge, and it has no other way to stall the sequencer.

Top module: `dma_single_seq`

## Requirements
- R1: After reset, `aen`, `dak`, `memr`, `memw`, `ior`, `iow` and `tc` are all 0, `bus_addr` is 0, and every bit of `chan_masked` is 1.
- R2: A channel is eligible when its `drq` bit is 1, its mask is clear and `ctrl_disable` is 0. When the sequencer is idle and any channel is eligible, it grants the lowest-numbered eligible channel (channel 0 wins). In the next cycle it raises `aen` and that channel's `dak` bit, and only that bit.
- R3: The sequencer never grants a masked channel, and it grants no channel while `ctrl_disable` is 1. A `drq` that rises and falls while another transfer is in progress, and is low again by the time the sequencer next samples, gets no grant.
- R4: Each transfer takes exactly four cycles, in this order:
  - Arbitrate: the requests are sampled.
  - Acknowledge: `aen` and `dak` are high.
  - Strobe: `aen` and `dak` stay high, `bus_addr` carries the channel's current address and the command strobes fire.
  - Release: `aen`, `dak`, the strobes and `bus_addr` all return to 0.
- R5: The channel's 2-bit field `xfer_type[2c+1:2c]` selects which strobes fire in the strobe cycle:
  - 01 (device to memory) asserts `ior` and `memw`.
  - 10 (memory to device) asserts `memr` and `iow`.
  - 00 (verify) and 11 (reserved) assert no strobe, but the address and count still advance.
- R6: After each byte, the channel's current address steps by +1 when `addr_dec[c]` is 0 and by -1 when it is 1. The step wraps modulo 2^16.
- R7: The count drops by one after each byte. The byte moved when the count was already 0 is the last one, so a programmed count of N gives N+1 transfers. `tc` is high for exactly the release cycle of that last byte.
- R8: On terminal count, a channel with `auto_init[c]` = 0 sets its mask bit. A channel with `auto_init[c]` = 1 instead reloads its current address and count from the values last programmed, and its mask stays clear.
- R9: A `cfg_wr` pulse loads `cfg_addr` and `cfg_count` into channel `cfg_ch`, as both the reload copy and the current value. `mask_set[c]` sets the mask of channel c and `mask_clr[c]` clears it, and each takes effect one cycle later on `chan_masked`.
- R10: The bus is released after every byte, even when `drq` stays high. The next grant comes only after the release cycle, and it is decided again by priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| drq | input | 4 | Per-channel service requests |
| ctrl_disable | input | 1 | When 1, no channel is granted |
| xfer_type | input | 8 | Per-channel transfer type, 2 bits per channel |
| addr_dec | input | 4 | Per-channel address direction (1 = decrement) |
| auto_init | input | 4 | Per-channel reload on terminal count |
| cfg_wr | input | 1 | Load strobe for one channel's address and count |
| cfg_ch | input | 2 | Channel that `cfg_wr` loads |
| cfg_addr | input | 16 | Start address to load |
| cfg_count | input | 16 | Transfer count to load (N gives N+1 bytes) |
| mask_set | input | 4 | Per-channel mask set pulses |
| mask_clr | input | 4 | Per-channel mask clear pulses |
| aen | output | 1 | Sequencer owns the bus |
| dak | output | 4 | One-hot acknowledge to the granted channel |
| bus_addr | output | 16 | Memory address during the strobe cycle |
| memr | output | 1 | Memory read strobe |
| memw | output | 1 | Memory write strobe |
| ior | output | 1 | I/O read strobe |
| iow | output | 1 | I/O write strobe |
| tc | output | 1 | Terminal count pulse |
| chan_masked | output | 4 | Current per-channel mask bits |

## Verification
Several properties are checked on every cycle:
- `dak` is one-hot and only ever high together with `aen`.
- No channel is granted unless it was eligible in the cycle before.
- A read strobe and a write strobe of the same space never fire together.
- `tc` is a single pulse that falls in a release cycle.
- Each step of the address and count has the right sign and size.
- A non-reloading channel masks itself at terminal count.

The rest needs the bench's scenarios:
- The priority order among several simultaneous requests.
- Strobe pairing for each transfer type.
- The N+1 byte count.
- Auto-reload restoring the start address.
- Address wrap on decrement.
- A request that pulses only while another transfer is in progress.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  typedef enum logic [1:0] {
    ST_ARB = 2'd0,
    ST_ACK = 2'd1,
    ST_STB = 2'd2,
    ST_REL = 2'd3
  } seq_state_t;

  typedef enum logic [1:0] {
    XT_VERIFY = 2'd0,
    XT_DEV2MEM = 2'd1,
    XT_MEM2DEV = 2'd2,
    XT_RSVD = 2'd3
  } xfer_kind_t;

endpackage

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
  parameter int NCH = 4,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0] req,
  output logic           any,
  output logic [CHW-1:0] idx
);

  logic [NCH:0]   seen;
  logic [NCH-1:0] win;

  assign seen[0] = 1'b0;

  // A channel wins only if no lower-numbered channel is requesting.
  for (genvar g = 0; g < NCH; g++) begin : g_chain
    assign win[g]      = req[g] & ~seen[g];
    assign seen[g + 1] = seen[g] | req[g];
  end

  assign any = seen[NCH];

  always_comb begin
    idx = '0;
    for (int i = 0; i < NCH; i++) begin
      if (win[i]) idx = CHW'(i);
    end
  end

endmodule

// File: rtl/dma_chan_ctx.sv
module dma_chan_ctx #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [AW-1:0] ld_addr,
  input  logic [CW-1:0] ld_cnt,
  input  logic          step,
  input  logic          dec,
  input  logic          auto_en,
  input  logic          mset,
  input  logic          mclr,
  output logic [AW-1:0] cur_addr,
  output logic [CW-1:0] cur_cnt,
  output logic          masked
);

  logic [AW-1:0] base_addr;
  logic [CW-1:0] base_cnt;
  logic          last_byte;

  assign last_byte = (cur_cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_addr <= '0;
      base_cnt  <= '0;
      cur_addr  <= '0;
      cur_cnt   <= '0;
    end else if (ld) begin
      base_addr <= ld_addr;
      base_cnt  <= ld_cnt;
      cur_addr  <= ld_addr;
      cur_cnt   <= ld_cnt;
    end else if (step) begin
      if (last_byte && auto_en) begin
        cur_addr <= base_addr;
        cur_cnt  <= base_cnt;
      end else begin
        cur_addr <= dec ? cur_addr - 1'b1 : cur_addr + 1'b1;
        cur_cnt  <= cur_cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      masked <= 1'b1;
    end else if (mset || (step && !ld && last_byte && !auto_en)) begin
      masked <= 1'b1;
    end else if (mclr) begin
      masked <= 1'b0;
    end
  end

  // R6: the address moves by exactly one in the programmed direction
  a_r6_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !ld && !last_byte) |=>
      (cur_addr == ($past(dec) ? AW'($past(cur_addr) - 1'b1)
                               : AW'($past(cur_addr) + 1'b1))));

  // R7: the count drops by one per byte
  a_r7_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !ld && !last_byte) |=> (cur_cnt == CW'($past(cur_cnt) - 1'b1)));

  // R8: a non-reloading channel masks itself on its last byte
  a_r8_mask_on_tc: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !ld && last_byte && !auto_en) |=> masked);

endmodule

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
  import dma_seq_pkg::*;
#(
  parameter int NCH = 4,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] elig,
  input  logic           sel_last,
  output seq_state_t     state,
  output logic [CHW-1:0] sel,
  output logic [NCH-1:0] step_oh,
  output logic           tc
);

  seq_state_t     state_q;
  logic [CHW-1:0] sel_q;
  logic           tc_q;
  logic           pick_any;
  logic [CHW-1:0] pick_idx;

  dma_prio_pick #(.NCH(NCH)) u_pick (
    .req (elig),
    .any (pick_any),
    .idx (pick_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_ARB;
      sel_q   <= '0;
      tc_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_ARB: begin
          tc_q <= 1'b0;
          if (pick_any) begin
            sel_q   <= pick_idx;
            state_q <= ST_ACK;
          end
        end
        ST_ACK: state_q <= ST_STB;
        ST_STB: begin
          state_q <= ST_REL;
          tc_q    <= sel_last;
        end
        ST_REL: begin
          state_q <= ST_ARB;
          tc_q    <= 1'b0;
        end
        default: state_q <= ST_ARB;
      endcase
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_step
    assign step_oh[g] = (state_q == ST_STB) && (sel_q == CHW'(g));
  end

  assign state = state_q;
  assign sel   = sel_q;
  assign tc    = tc_q;

  // R7: terminal count is a single-cycle pulse
  a_r7_tc_single: assert property (@(posedge clk) disable iff (!rst_n)
    tc_q |=> !tc_q);

  // R10: a release cycle is always followed by a fresh arbitration
  a_r10_rel_then_arb: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_REL) |=> (state_q == ST_ARB));

endmodule

// File: rtl/dma_single_seq.sv
module dma_single_seq
  import dma_seq_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int CW  = 16,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   drq,
  input  logic             ctrl_disable,
  input  logic [2*NCH-1:0] xfer_type,
  input  logic [NCH-1:0]   addr_dec,
  input  logic [NCH-1:0]   auto_init,
  input  logic             cfg_wr,
  input  logic [CHW-1:0]   cfg_ch,
  input  logic [AW-1:0]    cfg_addr,
  input  logic [CW-1:0]    cfg_count,
  input  logic [NCH-1:0]   mask_set,
  input  logic [NCH-1:0]   mask_clr,
  output logic             aen,
  output logic [NCH-1:0]   dak,
  output logic [AW-1:0]    bus_addr,
  output logic             memr,
  output logic             memw,
  output logic             ior,
  output logic             iow,
  output logic             tc,
  output logic [NCH-1:0]   chan_masked
);

  logic [AW-1:0]  ch_addr [NCH];
  logic [CW-1:0]  ch_cnt  [NCH];
  logic [NCH-1:0] ch_mask;
  logic [NCH-1:0] step_oh;
  logic [NCH-1:0] elig;
  seq_state_t     state;
  logic [CHW-1:0] sel;
  logic           sel_last;
  xfer_kind_t     sel_kind;
  logic           on_bus;
  logic           strobing;

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    dma_chan_ctx #(.AW(AW), .CW(CW)) u_ctx (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld       (cfg_wr && (cfg_ch == CHW'(g))),
      .ld_addr  (cfg_addr),
      .ld_cnt   (cfg_count),
      .step     (step_oh[g]),
      .dec      (addr_dec[g]),
      .auto_en  (auto_init[g]),
      .mset     (mask_set[g]),
      .mclr     (mask_clr[g]),
      .cur_addr (ch_addr[g]),
      .cur_cnt  (ch_cnt[g]),
      .masked   (ch_mask[g])
    );
  end

  assign elig = drq & ~ch_mask & {NCH{~ctrl_disable}};

  assign sel_last = (ch_cnt[sel] == '0);
  assign sel_kind = xfer_kind_t'(xfer_type[2*sel +: 2]);

  dma_seq_fsm #(.NCH(NCH)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .elig     (elig),
    .sel_last (sel_last),
    .state    (state),
    .sel      (sel),
    .step_oh  (step_oh),
    .tc       (tc)
  );

  assign on_bus   = (state == ST_ACK) || (state == ST_STB);
  assign strobing = (state == ST_STB);

  always_comb begin
    dak = '0;
    if (on_bus) dak[sel] = 1'b1;
  end

  assign aen      = on_bus;
  assign bus_addr = strobing ? ch_addr[sel] : '0;
  assign ior      = strobing && (sel_kind == XT_DEV2MEM);
  assign memw     = strobing && (sel_kind == XT_DEV2MEM);
  assign memr     = strobing && (sel_kind == XT_MEM2DEV);
  assign iow      = strobing && (sel_kind == XT_MEM2DEV);
  assign chan_masked = ch_mask;

  // R2: at most one acknowledge at a time
  a_r2_dak_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dak));

  // R4: an acknowledge is only ever given while the bus is held
  a_r4_dak_needs_aen: assert property (@(posedge clk) disable iff (!rst_n)
    (|dak) |-> aen);

  // R3: the granted channel was eligible when sampled
  a_r3_grant_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aen) |-> (|($past(elig) & dak)));

  // R5: reads and writes of the same space never overlap
  a_r5_no_clash: assert property (@(posedge clk) disable iff (!rst_n)
    !(memr && memw) && !(ior && iow));

  // R7: terminal count lands in the release cycle of a transfer
  a_r7_tc_in_release: assert property (@(posedge clk) disable iff (!rst_n)
    tc |-> (!aen && $past(aen)));

endmodule

// File: tb/sim_dma_single_seq.sv
module sim_dma_single_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  drq = '0;
  logic        ctrl_disable = 1'b0;
  logic [7:0]  xfer_type = {2'b11, 2'b00, 2'b10, 2'b01};
  logic [3:0]  addr_dec = 4'b0010;
  logic [3:0]  auto_init = 4'b0100;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_ch = '0;
  logic [15:0] cfg_addr = '0;
  logic [15:0] cfg_count = '0;
  logic [3:0]  mask_set = '0;
  logic [3:0]  mask_clr = '0;
  logic        aen, memr, memw, ior, iow, tc;
  logic [3:0]  dak, chan_masked;
  logic [15:0] bus_addr;

  int n_chk = 0;
  int n_bad = 0;

  logic [15:0] m_addr [4];
  logic [15:0] m_cnt  [4];
  logic [15:0] b_addr [4];
  logic [15:0] b_cnt  [4];
  logic        m_mask [4];

  always #2.5 clk = ~clk;

  dma_single_seq u0 (
    .clk, .rst_n, .drq, .ctrl_disable, .xfer_type, .addr_dec, .auto_init,
    .cfg_wr, .cfg_ch, .cfg_addr, .cfg_count, .mask_set, .mask_clr,
    .aen, .dak, .bus_addr, .memr, .memw, .ior, .iow, .tc, .chan_masked
  );

  // Table: {drq, expected one-hot grant}
  localparam logic [7:0] VEC [8] = '{
    {4'b1111, 4'b0001}, {4'b1110, 4'b0010}, {4'b1100, 4'b0100},
    {4'b1000, 4'b1000}, {4'b0110, 4'b0010}, {4'b0100, 4'b0100},
    {4'b0100, 4'b0100}, {4'b0000, 4'b0000}
  };

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  endtask

  task automatic load(input int c, input logic [15:0] a, input logic [15:0] n);
    cfg_wr = 1'b1; cfg_ch = 2'(c); cfg_addr = a; cfg_count = n;
    @(negedge clk);
    cfg_wr = 1'b0;
    b_addr[c] = a; b_cnt[c] = n; m_addr[c] = a; m_cnt[c] = n;
  endtask

  // Called at a negedge with the sequencer idle in arbitration.
  task automatic xfer(input logic [3:0] req, input logic [3:0] exp,
                      input logic [3:0] ack_drq, input logic [3:0] late_drq,
                      input string tag);
    int c = 0;
    logic [1:0] k;
    logic e_tc;
    for (int i = 0; i < 4; i++) if (exp[i]) c = i;
    drq = req;
    @(negedge clk);
    chk(aen == (exp != 0), {tag, " R2 aen"}, 32'(aen), 32'(exp != 0));
    chk(dak == exp, {tag, " R2 dak"}, 32'(dak), 32'(exp));
    if (exp == 0) begin
      drq = '0;
      return;
    end
    drq = ack_drq;
    @(negedge clk);
    drq = late_drq;
    k = xfer_type[2*c +: 2];
    chk(aen && dak == exp, {tag, " R4 held"}, 32'(dak), 32'(exp));
    chk(bus_addr == m_addr[c], {tag, " R4 addr"}, 32'(bus_addr), 32'(m_addr[c]));
    chk({memr, memw, ior, iow} == {k == 2'b10, k == 2'b01, k == 2'b01, k == 2'b10},
        {tag, " R5 strobes"}, 32'({memr, memw, ior, iow}),
        32'({k == 2'b10, k == 2'b01, k == 2'b01, k == 2'b10}));
    e_tc = (m_cnt[c] == 16'h0);
    @(negedge clk);
    chk(!aen && dak == 0 && {memr, memw, ior, iow} == 0 && bus_addr == 0,
        {tag, " R10 release"}, 32'({aen, dak}), 32'h0);
    chk(tc == e_tc, {tag, " R7 tc"}, 32'(tc), 32'(e_tc));
    if (e_tc && auto_init[c]) begin
      m_addr[c] = b_addr[c]; m_cnt[c] = b_cnt[c];
    end else begin
      m_addr[c] = addr_dec[c] ? m_addr[c] - 16'd1 : m_addr[c] + 16'd1;
      m_cnt[c] = m_cnt[c] - 16'd1;
      if (e_tc) m_mask[c] = 1'b1;
    end
    @(negedge clk);
    chk(!tc, {tag, " R7 tc width"}, 32'(tc), 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 4; i++) m_mask[i] = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!aen && dak == 0 && !tc && {memr, memw, ior, iow} == 0 && bus_addr == 0,
        "R1 outputs idle", 32'({aen, dak, tc}), 32'h0);
    chk(chan_masked == 4'hF, "R1 masks set", 32'(chan_masked), 32'hF);
    // R3: everything masked after reset
    xfer(4'b1111, 4'b0000, 4'b0, 4'b0, "R3 masked at reset");

    // R9: program channels, clear masks
    load(0, 16'h1000, 16'h0020);
    load(1, 16'h2000, 16'h0020);
    load(2, 16'h3000, 16'h0001);
    load(3, 16'h4000, 16'h0020);
    mask_clr = 4'hF;
    @(negedge clk);
    mask_clr = 4'h0;
    for (int i = 0; i < 4; i++) m_mask[i] = 1'b0;
    chk(chan_masked == 4'h0, "R9 mask clear", 32'(chan_masked), 32'h0);

    // Table walk: priority, strobe pairing, stepping, auto reload
    for (int i = 0; i < 8; i++) xfer(VEC[i][7:4], VEC[i][3:0], 4'b0, 4'b0, "R2,R5,R6,R8 vec");
    chk(chan_masked[2] == 1'b0, "R8 auto keeps mask clear", 32'(chan_masked), 32'h0);

    // R3 and R9: masked channel is skipped
    mask_set = 4'b0001;
    @(negedge clk);
    mask_set = 4'b0;
    chk(chan_masked[0] == 1'b1, "R9 mask set", 32'(chan_masked), 32'h1);
    xfer(4'b0001, 4'b0000, 4'b0, 4'b0, "R3 masked ch0");
    xfer(4'b0011, 4'b0010, 4'b0, 4'b0, "R3 masked ch0 skipped");
    mask_clr = 4'b0001;
    @(negedge clk);
    mask_clr = 4'b0;

    // R3: controller disabled
    ctrl_disable = 1'b1;
    xfer(4'b1111, 4'b0000, 4'b0, 4'b0, "R3 disabled");
    ctrl_disable = 1'b0;

    // R3: request that pulses during another transfer is ignored
    xfer(4'b0010, 4'b0010, 4'b0001, 4'b0000, "R3 pulse");
    xfer(4'b0000, 4'b0000, 4'b0, 4'b0, "R3 pulse ignored");

    // R10: drq held; bus still released, priority re-decided
    xfer(4'b0011, 4'b0001, 4'b0011, 4'b0011, "R10 held 1");
    xfer(4'b0011, 4'b0001, 4'b0011, 4'b0011, "R10 held 2");
    drq = '0;

    // R6: decrement wraps below zero
    load(1, 16'h0000, 16'h0005);
    xfer(4'b0010, 4'b0010, 4'b0, 4'b0, "R6 wrap a");
    xfer(4'b0010, 4'b0010, 4'b0, 4'b0, "R6 wrap b");

    // R7: count of 2 gives three bytes, tc only on the third
    load(0, 16'h0100, 16'h0002);
    for (int i = 0; i < 3; i++) xfer(4'b0001, 4'b0001, 4'b0, 4'b0, "R7 three bytes");
    chk(chan_masked[0] == 1'b1, "R8 ch0 masked after tc", 32'(chan_masked), 32'h1);
    xfer(4'b0001, 4'b0000, 4'b0, 4'b0, "R8 ch0 no further grant");

    // R8: reserved type, count 0, single byte then masked
    load(3, 16'h4000, 16'h0000);
    xfer(4'b1000, 4'b1000, 4'b0, 4'b0, "R5,R8 ch3 last");
    chk(chan_masked[3] == 1'b1, "R8 ch3 masked", 32'(chan_masked), 32'h8);
    xfer(4'b1000, 4'b0000, 4'b0, 4'b0, "R8 ch3 no grant");

    finish_run();
  end

endmodule